// File: doc/BRIEF.md
# Transition Watchdog with Repeating Reset

This block watches a single watchdog input. Software or firmware is expected to toggle that input. If no edge arrives within a programmable timeout, the block lowers a watchdog status output and raises a reset request pulse. The pulse lasts one sixth of the timeout. The status output stays low until the input changes again. If the input never moves, the timeout is counted again from the end of each pulse, so reset pulses keep recurring.

Time is measured in units. One unit is `UNIT_TICKS` strobes of the `tick` input, which comes from a prescaler elsewhere. A 3-bit rate code selects one of eight timeout/reset pairs. Two qualifying inputs disable the whole function: one flags that the watchdog input is left floating, the other flags a power failure. Sensing the floating level is done outside this block.

Top module: `wdog_transition`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `wd_ok` is 1 and `reset_req` is 0.
- R2: The timeout in units is 6<<(code-1) for codes 1..6 (6, 12, 24, 48, 96, 192). Code 0 gives 384 units and code 7 gives 768 units. The value is `BASE_UNITS` (6) shifted by the per-code amount.
- R3: Each `reset_req` pulse lasts exactly one sixth of the selected timeout: 64, 1, 2, 4, 8, 16, 32 or 128 units for codes 0 to 7.
- R4: `wd_ok` goes low in the same cycle that `reset_req` rises, and it stays low until the next input edge. An edge that arrives during a pulse raises `wd_ok`, but the pulse still runs to its full length.
- R5: With a static input, the next timeout starts when a pulse ends. Pulses therefore repeat every timeout plus reset width.
- R6: A rising or a falling edge on `wd_in` restarts the timeout. The input passes through two synchronizer flops and an edge register, so a change takes effect on the third clock edge after it.
- R7: While `wd_float` or `pwr_fail` is high, `wd_ok` is 1, `reset_req` is 0 and the timer is cleared. After release, timing starts from zero.
- R8: A change of rate code restarts the current period from zero, on the first clock edge after the change.
- R9: The timer advances only on cycles with `tick` high. With `tick` held low, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled timing strobe |
| wd_in | input | 1 | Watchdog input, asynchronous |
| wd_float | input | 1 | Watchdog input is floating; disables the function |
| pwr_fail | input | 1 | Power failure; disables the function |
| rate | input | 3 | Timeout/reset rate code |
| wd_ok | output | 1 | High while serviced; low after a timeout until the next edge |
| reset_req | output | 1 | Reset pulse request |

## Verification
Every rate code is timed exactly to the rising edge of its first pulse. The bench also measures the pulse width and the gap to the following pulse. A design that starts the next timeout at pulse start, rather than at pulse end, shows a gap that is too short. Edges arrive just before the deadline, so a timer that restarts on one polarity only trips. The restart latency is checked to the cycle, which exposes a synchronizer of the wrong depth. Further tests place an edge inside a pulse, change the rate code midway through a period, disable the block while `wd_ok` is latched low, and hold `tick` low. These catch designs that cut the pulse short, only adopt the new limit, keep a stale status, or count clocks instead of ticks.

// File: rtl/wdog_transition.sv
module wdog_transition #(
  parameter int UNIT_TICKS = 4,
  parameter int BASE_UNITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wd_in,
  input  logic       wd_float,
  input  logic       pwr_fail,
  input  logic [2:0] rate,
  output logic       wd_ok,
  output logic       reset_req
);
  localparam int CW = $clog2(BASE_UNITS * 128) + 1;
  localparam int PW = $clog2(UNIT_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_TICKS - 1);

  logic [2:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] units_q;
  logic [2:0]    rate_q;
  logic          in_rst_q;
  logic          ok_q;
  logic [2:0]    sh;
  logic [CW-1:0] lim;

  wire dis    = wd_float | pwr_fail;
  wire edge_s = sync_q[1] ^ sync_q[2];
  wire strobe = tick && (pre_q == PRE_LAST);
  wire expire = strobe && (units_q == lim - CW'(1));

  always_comb begin
    case (rate)
      3'd0:    sh = 3'd6;
      3'd7:    sh = 3'd7;
      default: sh = rate - 3'd1;
    endcase
  end

  assign lim = in_rst_q ? (CW'(BASE_UNITS / 6) << sh) : (CW'(BASE_UNITS) << sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      rate_q <= 3'd0;
    end else begin
      sync_q <= {sync_q[1:0], wd_in};
      rate_q <= rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      units_q  <= '0;
      in_rst_q <= 1'b0;
      ok_q     <= 1'b1;
    end else if (dis) begin
      pre_q    <= '0;
      units_q  <= '0;
      in_rst_q <= 1'b0;
      ok_q     <= 1'b1;
    end else begin
      if (edge_s) ok_q <= 1'b1;
      if (rate != rate_q || (edge_s && !in_rst_q)) begin
        pre_q   <= '0;
        units_q <= '0;
      end else begin
        if (tick) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PW'(1);
        if (expire) begin
          units_q  <= '0;
          in_rst_q <= !in_rst_q;
          if (!in_rst_q) ok_q <= 1'b0;
        end else if (strobe) begin
          units_q <= units_q + CW'(1);
        end
      end
    end
  end

  assign wd_ok     = ok_q;
  assign reset_req = in_rst_q;
endmodule

// File: rtl/wdog_transition_chk.sv
module wdog_transition_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_float,
  input logic pwr_fail,
  input logic wd_ok,
  input logic reset_req
);
  assert_low_at_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> !wd_ok);

  assert_fall_only_at_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_ok) |-> $rose(reset_req));

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_float || pwr_fail) |=> (wd_ok && !reset_req));

  assert_gap_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reset_req) && !wd_float && !pwr_fail) |=> !reset_req);
endmodule

bind wdog_transition wdog_transition_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wd_float(wd_float), .pwr_fail(pwr_fail),
  .wd_ok(wd_ok), .reset_req(reset_req)
);

// File: tb/wdog_transition_tb_top.sv
`timescale 1ns/1ps
module wdog_transition_tb_top;
  localparam int U = 2;
  localparam int VEC [0:7][0:2] = '{
    '{0, 384, 64}, '{1, 6, 1}, '{2, 12, 2}, '{3, 24, 4},
    '{4, 48, 8}, '{5, 96, 16}, '{6, 192, 32}, '{7, 768, 128}
  };

  logic clk = 0, rst_n = 0, tick = 1, wd_in = 0, wd_float = 1, pwr_fail = 0;
  logic [2:0] rate = 3'd0;
  logic wd_ok, reset_req;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wdog_transition #(.UNIT_TICKS(U), .BASE_UNITS(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_in(wd_in), .wd_float(wd_float),
    .pwr_fail(pwr_fail), .rate(rate), .wd_ok(wd_ok), .reset_req(reset_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (reset_req !== lvl && n < 5000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh(input logic [2:0] code);
    wd_float = 1;
    rate = code;
    idle(5);
    wd_float = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    idle(3);
    chk(wd_ok === 1'b1 && reset_req === 1'b0, "R1 during reset", {wd_ok, reset_req}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(wd_ok === 1'b1 && reset_req === 1'b0, "R1 after reset", {wd_ok, reset_req}, 2);

    for (int i = 0; i < 8; i++) begin
      fresh(3'(VEC[i][0]));
      count_until(1'b1, n);
      chk(n == VEC[i][1] * U, "R2 timeout", n, VEC[i][1] * U);
      chk(wd_ok === 1'b0, "R4 low at pulse", wd_ok, 0);
      count_until(1'b0, n);
      chk(n == VEC[i][2] * U, "R3 pulse width", n, VEC[i][2] * U);
      chk(wd_ok === 1'b0, "R4 stays low", wd_ok, 0);
      count_until(1'b1, n);
      chk(n == VEC[i][1] * U, "R5 repeat interval", n, VEC[i][1] * U);
    end

    fresh(3'd1);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      wd_in = ~wd_in;
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (reset_req || !wd_ok) seen++;
      end
    end
    chk(seen == 0, "R6 both edges restart", seen, 0);
    wd_in = ~wd_in;
    count_until(1'b1, n);
    chk(n == 3 + 12, "R6 restart latency", n, 15);

    fresh(3'd3);
    count_until(1'b1, n);
    chk(n == 48, "R2 code3 timeout", n, 48);
    wd_in = ~wd_in;
    idle(4);
    chk(wd_ok === 1'b1, "R4 edge raises ok", wd_ok, 1);
    chk(reset_req === 1'b1, "R4 pulse completes", reset_req, 1);
    count_until(1'b0, n);
    chk(n == 4, "R4 pulse remainder", n, 4);

    fresh(3'd2);
    idle(10);
    rate = 3'd3;
    count_until(1'b1, n);
    chk(n == 1 + 48, "R8 rate change restart", n, 49);

    fresh(3'd1);
    pwr_fail = 1;
    seen = 0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (reset_req || !wd_ok) seen++;
    end
    chk(seen == 0, "R7 power fail disables", seen, 0);
    pwr_fail = 0;
    count_until(1'b1, n);
    chk(n == 12, "R7 fresh after release", n, 12);
    wd_float = 1;
    @(negedge clk);
    chk(wd_ok === 1'b1 && reset_req === 1'b0, "R7 float clears", {wd_ok, reset_req}, 2);

    tick = 0;
    fresh(3'd1);
    seen = 0;
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      if (reset_req) seen++;
    end
    chk(seen == 0, "R9 no tick no timeout", seen, 0);
    tick = 1;
    count_until(1'b1, n);
    chk(n == 12, "R9 timing resumes", n, 12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule